// File: doc/BRIEF.md
# Accumulator Pair Unit (multiply, divide and move registers)

This block keeps the two 32-bit result registers that sit beside the integer pipeline of a simple RISC core: an upper word and a lower word. It executes an unsigned multiply, an unsigned divide, a move of an operand into either word, and a read of either word. A multiply completes in the cycle it is accepted. A divide runs a restoring algorithm that produces one quotient bit per clock, and `busy` stays high for the 32 steps. An operation presented while `busy` is high is not taken, so the issuing stage holds it until the unit is free.

After a multiply or divide the unit counts its result as unread until either word is read. If software writes only one word with a move inside that window, the other word has no defined value. The unit raises a poison flag for that word, and every read of it returns a fixed poison pattern until the word is written again.

When `legacy_en` is high the unit also enforces an old spacing rule. Any write to the pair must have at least two accepted operations between it and the last read. A write that comes sooner raises a one-cycle `hazard` pulse.

Top module: `acc_pair_unit`

## Requirements
- R1: Opcode 0 (multiply) writes the 64-bit unsigned product of `opnd_a` and `opnd_b`. Bits 31:0 go to the lower word and bits 63:32 go to the upper word, in the same clock edge that accepts the operation.
- R2: Opcode 1 (divide) takes `opnd_a` as the dividend and `opnd_b` as the divisor. From the accepting edge, `busy` is high for exactly 32 cycles. No operation is accepted while `busy` is high. At the edge that drops `busy`, the quotient goes to the lower word and the remainder goes to the upper word.
- R3: A divide by zero does not trap. It leaves all ones in the lower word and the dividend in the upper word.
- R4: Opcode 2 copies `opnd_a` into the upper word and opcode 3 copies it into the lower word. Opcode 4 reads the upper word and opcode 5 reads the lower word. For a read, `rd_valid` is high for the one cycle after the accepting edge, with the data on `rd_data`. `rd_valid` is never high otherwise.
- R5: An opcode 2 inside the unread window sets `lower_poison`. While `lower_poison` is set, reads of the lower word return 32'hBAD0BAD0. The flag clears when the lower word is next written.
- R6: An opcode 3 inside the unread window sets `upper_poison`, with the same read behaviour and clearing rule as R5, applied to the upper word.
- R7: A completed multiply or divide opens the unread window and clears both poison flags. A read or a move closes the window. A move outside the window poisons nothing.
- R8: With `legacy_en` high, a write (opcodes 0 to 3) accepted with fewer than two accepted operations since the last accepted read raises `hazard` for the one cycle after its accepting edge.
- R9: With `legacy_en` low at the accepting edge, `hazard` stays low in the following cycle.
- R10: A synchronous active-high `rst` clears both words, both poison flags, `busy`, `rd_valid` and `hazard`.
- R11: Opcodes 6 and 7 are no-ops. They change no register or flag, but they count as accepted operations for the spacing rule of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented |
| op_code | input | 3 | Operation code (see R1 to R4 and R11) |
| opnd_a | input | 32 | First operand: multiplicand, dividend or move source |
| opnd_b | input | 32 | Second operand: multiplier or divisor |
| legacy_en | input | 1 | Enables the read-to-write spacing check |
| rd_data | output | 32 | Data returned by a read |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| busy | output | 1 | A divide is in progress; operations are held |
| upper_poison | output | 1 | The upper word holds an undefined value |
| lower_poison | output | 1 | The lower word holds an undefined value |
| hazard | output | 1 | A spacing violation was detected (legacy mode) |

## Verification
The multiply is tried with all-ones operands, where a wrong carry into the upper word shows at once. It is also tried with mixed operands and with a zero operand. The divide is tried with a small exact case, with a divisor larger than the dividend (quotient zero, remainder equal to the dividend), with a divisor of one, and with a divisor of zero. Together these separate a swapped quotient and remainder, an off-by-one step count, and a wrong zero-divisor pattern. Single-word moves are placed both inside and outside the unread window, and the spacing rule is tried with zero, one and two operations between a read and a write, in both modes. A random operation stream then runs against a cycle-level model.

// File: rtl/acc_pair_pkg.sv
package acc_pair_pkg;

    typedef enum logic [2:0] {
        OP_MUL    = 3'd0,
        OP_DIV    = 3'd1,
        OP_SET_UP = 3'd2,
        OP_SET_LW = 3'd3,
        OP_GET_UP = 3'd4,
        OP_GET_LW = 3'd5,
        OP_NOP_A  = 3'd6,
        OP_NOP_B  = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_DIVIDE = 1'b1
    } st_e;

    function automatic logic op_reads(input op_e op);
        return (op == OP_GET_UP) || (op == OP_GET_LW);
    endfunction

    function automatic logic op_writes(input op_e op);
        return (op == OP_MUL) || (op == OP_DIV) ||
               (op == OP_SET_UP) || (op == OP_SET_LW);
    endfunction

endpackage

// File: rtl/acc_div_core.sv
// Restoring unsigned divider datapath: one quotient bit per step.
module acc_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo_nxt,
    output logic [W-1:0] rem_nxt
);
    logic [W-1:0] part_q;
    logic [W-1:0] shq_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         fits;

    always_comb begin
        shifted = {part_q, shq_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = shifted >= {1'b0, dvs_q};
        rem_nxt = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_nxt = {shq_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            shq_q  <= '0;
            dvs_q  <= '0;
        end else if (load) begin
            part_q <= '0;
            shq_q  <= dividend;
            dvs_q  <= divisor;
        end else if (step) begin
            part_q <= rem_nxt;
            shq_q  <= quo_nxt;
        end
    end

endmodule

// File: rtl/acc_gap_tracker.sv
// Counts accepted operations since the last read and flags close writes.
module acc_gap_tracker #(
    parameter int MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic rd_op,
    input  logic wr_op,
    input  logic legacy_en,
    output logic hazard
);
    localparam int CW = $clog2(MIN_GAP + 1);

    logic [CW-1:0] since_q;
    logic          too_close;

    assign too_close = since_q < CW'(MIN_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= CW'(MIN_GAP);
            hazard  <= 1'b0;
        end else begin
            hazard <= accept && wr_op && legacy_en && too_close;
            if (accept) begin
                if (rd_op)
                    since_q <= '0;
                else if (too_close)
                    since_q <= since_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/acc_pair_unit.sv
module acc_pair_unit
    import acc_pair_pkg::*;
#(
    parameter int           W       = 32,
    parameter int           MIN_GAP = 2,
    parameter logic [W-1:0] POISON  = 'hBAD0BAD0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         legacy_en,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         busy,
    output logic         upper_poison,
    output logic         lower_poison,
    output logic         hazard
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    st_e              st_q, st_d;
    op_e              op;
    logic             accept;
    logic             last;
    logic [CNT_W-1:0] step_cnt;
    logic [W-1:0]     reg_up, reg_lw;
    logic             unread;
    logic [2*W-1:0]   prod;
    logic [W-1:0]     quo_nxt, rem_nxt;

    assign op     = op_e'(op_code);
    assign accept = op_valid && (st_q == ST_IDLE);
    assign last   = step_cnt == LAST_STEP;
    assign busy   = st_q == ST_DIVIDE;
    assign prod   = {{W{1'b0}}, opnd_a} * {{W{1'b0}}, opnd_b};

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // Transitions: IDLE -> DIVIDE on an accepted divide, DIVIDE -> IDLE after the last step
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (accept && op == OP_DIV) st_d = ST_DIVIDE;
            ST_DIVIDE: if (last) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            step_cnt <= '0;
        else if (accept && op == OP_DIV)
            step_cnt <= '0;
        else if (st_q == ST_DIVIDE)
            step_cnt <= step_cnt + 1'b1;
    end

    acc_div_core #(.W(W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && op == OP_DIV),
        .step     (st_q == ST_DIVIDE),
        .dividend (opnd_a),
        .divisor  (opnd_b),
        .quo_nxt  (quo_nxt),
        .rem_nxt  (rem_nxt)
    );

    acc_gap_tracker #(.MIN_GAP(MIN_GAP)) gap_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .rd_op     (op_reads(op)),
        .wr_op     (op_writes(op)),
        .legacy_en (legacy_en),
        .hazard    (hazard)
    );

    // Registers, flags and read port
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_up       <= '0;
            reg_lw       <= '0;
            unread       <= 1'b0;
            upper_poison <= 1'b0;
            lower_poison <= 1'b0;
            rd_valid     <= 1'b0;
            rd_data      <= '0;
        end else begin
            rd_valid <= accept && op_reads(op);
            if (st_q == ST_DIVIDE && last) begin
                reg_up       <= rem_nxt;
                reg_lw       <= quo_nxt;
                unread       <= 1'b1;
                upper_poison <= 1'b0;
                lower_poison <= 1'b0;
            end else if (accept) begin
                unique case (op)
                    OP_MUL: begin
                        reg_up       <= prod[2*W-1:W];
                        reg_lw       <= prod[W-1:0];
                        unread       <= 1'b1;
                        upper_poison <= 1'b0;
                        lower_poison <= 1'b0;
                    end
                    OP_SET_UP: begin
                        reg_up       <= opnd_a;
                        upper_poison <= 1'b0;
                        if (unread) lower_poison <= 1'b1;
                        unread       <= 1'b0;
                    end
                    OP_SET_LW: begin
                        reg_lw       <= opnd_a;
                        lower_poison <= 1'b0;
                        if (unread) upper_poison <= 1'b1;
                        unread       <= 1'b0;
                    end
                    OP_GET_UP: begin
                        rd_data <= upper_poison ? POISON : reg_up;
                        unread  <= 1'b0;
                    end
                    OP_GET_LW: begin
                        rd_data <= lower_poison ? POISON : reg_lw;
                        unread  <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/acc_pair_chk.sv
module acc_pair_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         accept,
    input logic [2:0]   op_code,
    input logic [W-1:0] opnd_a,
    input logic         legacy_en,
    input logic [W-1:0] reg_up,
    input logic         rd_valid,
    input logic         busy,
    input logic         upper_poison,
    input logic         lower_poison,
    input logic         hazard
);
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= 0;
        else              busy_run <= busy_run + 1;
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_run < W);

    p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_run == W - 1) |=> !busy);

    p_div_start_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && op_code == 3'd1) |=> busy);

    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && (op_code == 3'd4 || op_code == 3'd5)) |=> rd_valid);

    p_rd_only_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(accept && (op_code == 3'd4 || op_code == 3'd5)));

    p_set_up_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && op_code == 3'd2) |=> reg_up == $past(opnd_a));

    p_mul_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && op_code == 3'd0) |=> (!upper_poison && !lower_poison));

    p_no_haz_r9: assert property (@(posedge clk) disable iff (rst)
        !legacy_en |=> !hazard);

endmodule

bind acc_pair_unit acc_pair_chk #(.W(W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .op_code      (op_code),
    .opnd_a       (opnd_a),
    .legacy_en    (legacy_en),
    .reg_up       (reg_up),
    .rd_valid     (rd_valid),
    .busy         (busy),
    .upper_poison (upper_poison),
    .lower_poison (lower_poison),
    .hazard       (hazard)
);

// File: tb/acc_pair_unit_tb_top.sv
`timescale 1ns/1ps
module acc_pair_unit_tb_top;
    localparam logic [31:0] POISON = 32'hBAD0BAD0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        legacy_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid, busy, upper_poison, lower_poison, hazard;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    always #4 clk = ~clk;

    acc_pair_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .legacy_en(legacy_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .upper_poison(upper_poison), .lower_poison(lower_poison), .hazard(hazard)
    );

    // Behavioural reference model
    logic [31:0] m_up, m_lw, m_q, m_r, m_rdd;
    logic [63:0] m_prod;
    bit m_unread, m_pu, m_pl, m_rdv, m_haz;
    int m_busy, m_since;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_up = 0; m_lw = 0; m_unread = 0; m_pu = 0; m_pl = 0;
            m_rdv = 0; m_rdd = 0; m_haz = 0; m_busy = 0; m_since = 2;
        end else begin
            m_rdv = 0;
            m_haz = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    m_up = m_r; m_lw = m_q; m_unread = 1; m_pu = 0; m_pl = 0;
                end
            end else if (op_valid) begin
                if (legacy_en && op_code <= 3'd3 && m_since < 2) m_haz = 1;
                if (op_code == 3'd4 || op_code == 3'd5) m_since = 0;
                else if (m_since < 2) m_since++;
                case (op_code)
                    3'd0: begin
                        m_prod = {32'b0, opnd_a} * {32'b0, opnd_b};
                        m_up = m_prod[63:32]; m_lw = m_prod[31:0];
                        m_unread = 1; m_pu = 0; m_pl = 0;
                    end
                    3'd1: begin
                        m_busy = 32;
                        if (opnd_b == 0) begin m_q = 32'hFFFFFFFF; m_r = opnd_a; end
                        else begin m_q = opnd_a / opnd_b; m_r = opnd_a % opnd_b; end
                    end
                    3'd2: begin m_up = opnd_a; m_pu = 0; if (m_unread) m_pl = 1; m_unread = 0; end
                    3'd3: begin m_lw = opnd_a; m_pl = 0; if (m_unread) m_pu = 1; m_unread = 0; end
                    3'd4: begin m_rdv = 1; m_rdd = m_pu ? POISON : m_up; m_unread = 0; end
                    3'd5: begin m_rdv = 1; m_rdd = m_pl ? POISON : m_lw; m_unread = 0; end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 busy", {31'b0, busy}, {31'b0, m_busy > 0});
            check("R4 rd_valid", {31'b0, rd_valid}, {31'b0, m_rdv});
            if (m_rdv) check("R1/R2/R3/R4/R5/R6 rd_data", rd_data, m_rdd);
            check("R5 lower_poison", {31'b0, lower_poison}, {31'b0, m_pl});
            check("R6 upper_poison", {31'b0, upper_poison}, {31'b0, m_pu});
            check("R8/R9 hazard", {31'b0, hazard}, {31'b0, m_haz});
        end
    end

    // Issue at a negedge; the next call keeps op_valid high for back-to-back flow
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        while (busy) @(negedge clk);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        op_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic read_expect(input logic [2:0] op, input logic [31:0] exp, input string tag);
        issue(op, 0, 0);
        idle(0);
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state at the ports
        check("R10 busy", {31'b0, busy}, 32'd0);
        check("R10 rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R10 poison", {30'b0, upper_poison, lower_poison}, 32'd0);
        check("R10 hazard", {31'b0, hazard}, 32'd0);
        read_expect(3'd4, 32'd0, "R10 upper cleared");
        read_expect(3'd5, 32'd0, "R10 lower cleared");

        // R1: multiply patterns
        issue(3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        read_expect(3'd4, 32'hFFFFFFFE, "R1 upper all-ones product");
        read_expect(3'd5, 32'h00000001, "R1 lower all-ones product");
        issue(3'd0, 32'h12345678, 32'h9ABCDEF0);
        issue(3'd5, 0, 0); issue(3'd4, 0, 0); idle(1);
        issue(3'd0, 32'h0, 32'hDEADBEEF);
        issue(3'd4, 0, 0); idle(1);

        // R2: divide patterns
        issue(3'd1, 32'd1000, 32'd7);
        read_expect(3'd5, 32'd142, "R2 quotient");
        read_expect(3'd4, 32'd6, "R2 remainder");
        issue(3'd1, 32'd5, 32'd9);
        issue(3'd5, 0, 0); issue(3'd4, 0, 0);
        issue(3'd1, 32'hFFFFFFFF, 32'd1);
        issue(3'd6, 0, 0); issue(3'd5, 0, 0); idle(2);

        // R3: divide by zero
        issue(3'd1, 32'h0000ABCD, 32'd0);
        read_expect(3'd5, 32'hFFFFFFFF, "R3 lower all ones");
        read_expect(3'd4, 32'h0000ABCD, "R3 upper dividend");

        // R4: moves and reads
        issue(3'd2, 32'hCAFE0001, 0);
        issue(3'd3, 32'h0BEEF002, 0);
        read_expect(3'd4, 32'hCAFE0001, "R4 move upper");
        read_expect(3'd5, 32'h0BEEF002, "R4 move lower");

        // R5: move upper inside the unread window poisons lower
        issue(3'd0, 32'd3, 32'd5);
        issue(3'd2, 32'h11112222, 0);
        read_expect(3'd5, POISON, "R5 poisoned lower read");
        read_expect(3'd4, 32'h11112222, "R5 upper intact");
        issue(3'd3, 32'h33334444, 0);
        read_expect(3'd5, 32'h33334444, "R5 lower rewritten");

        // R6: move lower after a divide poisons upper; multiply clears (R7)
        issue(3'd1, 32'd77, 32'd10);
        issue(3'd3, 32'h55556666, 0);
        read_expect(3'd4, POISON, "R6 poisoned upper read");
        issue(3'd0, 32'd2, 32'd2);
        idle(1);
        check("R7 poison cleared", {30'b0, upper_poison, lower_poison}, 32'd0);

        // R7: a read closes the window, a later move poisons nothing
        issue(3'd0, 32'd9, 32'd9);
        issue(3'd4, 0, 0);
        issue(3'd2, 32'h77778888, 0);
        idle(1);
        check("R7 no poison after read", {31'b0, lower_poison}, 32'd0);

        // R8: spacing rule in legacy mode, R11 no-ops count as instructions
        legacy_en = 1'b1;
        issue(3'd4, 0, 0); issue(3'd3, 32'h1, 0); idle(0);
        check("R8 zero gap", {31'b0, hazard}, 32'd1);
        issue(3'd4, 0, 0); issue(3'd6, 0, 0); issue(3'd2, 32'h2, 0); idle(0);
        check("R8 one gap", {31'b0, hazard}, 32'd1);
        issue(3'd5, 0, 0); issue(3'd7, 0, 0); issue(3'd6, 0, 0); issue(3'd0, 32'h3, 32'h4); idle(0);
        check("R8 R11 two gap ok", {31'b0, hazard}, 32'd0);
        issue(3'd5, 0, 0); issue(3'd1, 32'd50, 32'd3); idle(1);
        idle(40);

        // R9: same close sequences with legacy off
        legacy_en = 1'b0;
        issue(3'd4, 0, 0); issue(3'd3, 32'h5, 0); idle(0);
        check("R9 zero gap no hazard", {31'b0, hazard}, 32'd0);
        issue(3'd5, 0, 0); issue(3'd0, 32'h6, 32'h7); idle(1);

        // Mixed random stream against the model
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) legacy_en = ~legacy_en;
            issue(3'($urandom_range(0, 7)),
                  ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 20)) : $urandom,
                  ($urandom_range(0, 4) == 0) ? 32'd0 : 32'($urandom_range(1, 1000)));
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(40);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule